// File: doc/BRIEF.md
# ADC Serial Lane Framer

This block turns 12-bit conversion results from one converter channel into a bit-serial stream on one or two data lanes, together with a word marker (frame) and a clock-enable that stands for the forwarded bit clock. Every cycle of `clk` is one bit tick, and each tick represents one edge of a double-data-rate output clock. The block therefore shifts out exactly one bit per lane per cycle, most significant bit first.

Samples arrive on a valid/ready stream and wait in a small buffer. When `smp_ready` is high, a sample offered with `smp_valid` is taken at that clock edge. The source is expected to hold off while `smp_ready` is low. A sample offered anyway is discarded, and this is reported on `overflow`. In single-lane mode each sample goes out in turn on lane 1. In dual-lane mode consecutive samples are dealt to lane 1 and lane 0, and the lane 0 words either coincide with the lane 1 words or trail them by half a word. Number format, test pattern, lane mode and alignment are sampled only at lane 1 word boundaries. Power-down freezes the stream at once.

Top module: `adc_lane_framer`

## Requirements
- R1: Out of reset, `clk_en`, `frame`, `lane0_en`, `lane1_bit`, `out_range` and `overflow` are all 0, and `smp_ready` is 1.
- R2: In single-lane mode (`dual_lane`=0) every buffered sample is sent on `lane1_bit` as a 12-tick word, most significant bit first, with consecutive samples in consecutive words. `lane0_en` stays 0.
- R3: While running, the tick counter cycles through 12 ticks. `frame` is 1 on ticks 0 to 5 and 0 on ticks 6 to 11, so it rises on the tick where each lane 1 word starts. `clk_en` is 1.
- R4: In dual-lane mode (`dual_lane`=1) `lane0_en` is 1. Of two consecutive samples, the older one goes to lane 1 and the next one goes to lane 0.
- R5: In dual-lane mode with `word_align`=1, lane 0 words start on the same tick as lane 1 words. With `word_align`=0 they start 6 ticks later, on the falling edge of `frame`. In single-lane mode `word_align` is treated as 0.
- R6: With `twos_fmt`=0 the word is the input code, which is offset binary. With `twos_fmt`=1 the word is that code with bit 11 inverted, which is two's complement.
- R7: A sample flagged with `smp_ovr`=1 is sent as 4095 (in offset binary) if its code bit 11 is 1, and as 0 otherwise. `out_range` is 1 for the 12 ticks of that word.
- R8: With `test_en`=1 every enabled lane sends the fixed word 101001100011 (hex A63, most significant bit first) in place of the sample data.
- R9: `dual_lane`, `word_align`, `twos_fmt` and `test_en` take effect only at the next lane 1 word start. A word already started finishes unchanged.
- R10: One cycle after `pwr_down` is seen high, `clk_en` and `frame` are 0 and both lanes hold their last bit. One cycle after it is seen low again, a new lane 1 word starts at tick 0.
- R11: `smp_ready` is 0 exactly when the 2-entry buffer is full. A strobe while `smp_ready` is 0 discards the sample and sets `overflow` for one cycle on the next cycle.
- R12: If no sample is buffered when a lane word starts and the test pattern is off, that word is all zeros and it does not raise `out_range`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-tick clock, one tick per output clock edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe (stream valid) |
| smp_ready | output | 1 | Buffer can accept a sample |
| smp_code | input | 12 | Conversion result, offset binary |
| smp_ovr | input | 1 | Sample is out of range |
| dual_lane | input | 1 | 1 = dual-lane mode, 0 = single-lane mode |
| word_align | input | 1 | 1 = lane 0 words aligned with lane 1 words (dual mode only) |
| twos_fmt | input | 1 | 1 = two's complement output, 0 = offset binary |
| test_en | input | 1 | Send the fixed test word |
| pwr_down | input | 1 | Freeze the output stream |
| lane1_bit | output | 1 | Lane 1 serial data |
| lane0_bit | output | 1 | Lane 0 serial data |
| lane0_en | output | 1 | Lane 0 driver enable (0 = high impedance) |
| frame | output | 1 | Word marker |
| clk_en | output | 1 | Forwarded bit clock is running |
| out_range | output | 1 | A word being sent came from an out-of-range sample |
| overflow | output | 1 | One-cycle pulse after a discarded strobe |

## Verification
All outputs are registered. Tick 0 of a word therefore becomes visible one edge after the edge where the counter wraps. The first such edge is the one that sees `pwr_down` low, so the bench fills the buffer while powered down, releases power-down at a falling clock edge, and reads tick n at the (n+1)-th falling edge after that. `overflow` and the power-down freeze each appear one edge after the stimulus edge, and the bench samples them at the next falling edge. Control changes are applied in the middle of a word, and the bench expects them only from the tick-0 sample of the following word.

// File: rtl/adc_framer_pkg.sv
package adc_framer_pkg;
  localparam int unsigned WORD_W    = 12;
  localparam int unsigned BUF_DEPTH = 2;
  localparam logic [WORD_W-1:0] TEST_WORD = 12'hA63;

  // Control set captured at each lane 1 word start.
  typedef struct packed {
    logic dual;
    logic align;
    logic twos;
    logic test;
  } ctl_t;
endpackage

// File: rtl/sample_buf.sv
module sample_buf #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [W-1:0]    push_code,
  input  logic            push_ovr,
  input  logic [1:0]      pop_cnt,
  output logic [W-1:0]    head0_code,
  output logic            head0_ovr,
  output logic [W-1:0]    head1_code,
  output logic            head1_ovr,
  output logic [CNTW-1:0] count,
  output logic            full
);
  logic [W:0]    mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [AW-1:0] rd_nxt1;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input int k);
    int s;
    s = int'(p) + k;
    if (s >= int'(DEPTH)) s = s - int'(DEPTH);
    return AW'(s);
  endfunction

  assign rd_nxt1 = step(rd_q, 1);
  assign {head0_ovr, head0_code} = mem[rd_q];
  assign {head1_ovr, head1_code} = mem[rd_nxt1];
  assign full = (count == CNTW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= {push_ovr, push_code};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      if (push) wr_q <= step(wr_q, 1);
      rd_q  <= step(rd_q, int'(pop_cnt));
      count <= count + CNTW'(push) - CNTW'(pop_cnt);
    end
  end
endmodule

// File: rtl/word_fmt.sv
module word_fmt #(
  parameter int unsigned W = 12,
  parameter logic [W-1:0] PATTERN = '0
) (
  input  logic         have,
  input  logic [W-1:0] code,
  input  logic         ovr,
  input  logic         twos,
  input  logic         test,
  output logic [W-1:0] word,
  output logic         flag
);
  always_comb begin
    word = ovr ? {W{code[W-1]}} : code;
    if (twos) word[W-1] = ~word[W-1];
    if (!have) word = '0;
    if (test) word = PATTERN;
    flag = have & ovr;
  end
endmodule

// File: rtl/lane_shift.sv
module lane_shift #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift_en,
  input  logic [W-1:0] word,
  input  logic         flag_in,
  output logic         bit_out,
  output logic         flag
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      flag <= 1'b0;
    end else if (load) begin
      sh_q <= word;
      flag <= flag_in;
    end else if (shift_en) begin
      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign bit_out = sh_q[W-1];
endmodule

// File: rtl/adc_lane_framer.sv
module adc_lane_framer
  import adc_framer_pkg::*;
#(
  parameter int unsigned W       = WORD_W,
  parameter int unsigned DEPTH   = BUF_DEPTH,
  parameter logic [W-1:0] PATTERN = TEST_WORD
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_valid,
  output logic         smp_ready,
  input  logic [W-1:0] smp_code,
  input  logic         smp_ovr,
  input  logic         dual_lane,
  input  logic         word_align,
  input  logic         twos_fmt,
  input  logic         test_en,
  input  logic         pwr_down,
  output logic         lane1_bit,
  output logic         lane0_bit,
  output logic         lane0_en,
  output logic         frame,
  output logic         clk_en,
  output logic         out_range,
  output logic         overflow
);
  localparam int unsigned CW   = $clog2(W);
  localparam int unsigned HALF = W / 2;
  localparam int unsigned LAST = W - 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic [CW-1:0]   cnt_q, cnt_n;
  logic            run_q, ovf_q;
  ctl_t            ctl_q, ctl_in, ctl_e;
  logic            active, start1, load0;
  logic [1:0]      ld, have, bits, flags;
  logic [1:0]      pop;
  logic [CNTW-1:0] count;
  logic            full;
  logic [W-1:0]    h0_code, h1_code;
  logic            h0_ovr, h1_ovr;
  logic [W-1:0]    code_sel [2];
  logic            ovr_sel  [2];
  logic [W-1:0]    wd       [2];
  logic [1:0]      wflag;

  assign active = ~pwr_down;
  assign cnt_n  = (cnt_q == CW'(LAST)) ? '0 : cnt_q + CW'(1);
  assign start1 = active && (cnt_n == '0);

  always_comb begin
    ctl_in.dual  = dual_lane;
    ctl_in.align = word_align & dual_lane;
    ctl_in.twos  = twos_fmt;
    ctl_in.test  = test_en;
    ctl_e = start1 ? ctl_in : ctl_q;
    load0 = active && ctl_e.dual &&
            (cnt_n == (ctl_e.align ? CW'(0) : CW'(HALF)));
    ld    = {start1, load0};
    have[1] = start1 && (count != '0);
    have[0] = load0 && (start1 ? (count >= CNTW'(2)) : (count != '0));
    pop   = {1'b0, have[1]} + {1'b0, have[0]};
    code_sel[1] = h0_code;
    ovr_sel[1]  = h0_ovr;
    code_sel[0] = start1 ? h1_code : h0_code;
    ovr_sel[0]  = start1 ? h1_ovr  : h0_ovr;
  end

  assign smp_ready = ~full;

  sample_buf #(.W(W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst),
    .push(smp_valid & ~full), .push_code(smp_code), .push_ovr(smp_ovr),
    .pop_cnt(pop),
    .head0_code(h0_code), .head0_ovr(h0_ovr),
    .head1_code(h1_code), .head1_ovr(h1_ovr),
    .count(count), .full(full)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    word_fmt #(.W(W), .PATTERN(PATTERN)) u_fmt (
      .have(have[g]), .code(code_sel[g]), .ovr(ovr_sel[g]),
      .twos(ctl_e.twos), .test(ctl_e.test),
      .word(wd[g]), .flag(wflag[g])
    );
    lane_shift #(.W(W)) u_sh (
      .clk(clk), .rst(rst), .load(ld[g]), .shift_en(active),
      .word(wd[g]), .flag_in(wflag[g]),
      .bit_out(bits[g]), .flag(flags[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CW'(LAST);
      run_q <= 1'b0;
      ctl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= smp_valid & full;
      if (active) begin
        cnt_q <= cnt_n;
        run_q <= 1'b1;
        if (start1) ctl_q <= ctl_in;
      end else begin
        cnt_q <= CW'(LAST);
        run_q <= 1'b0;
      end
    end
  end

  assign lane1_bit = bits[1];
  assign lane0_bit = bits[0];
  assign lane0_en  = ctl_q.dual;
  assign frame     = run_q && (cnt_q < CW'(HALF));
  assign clk_en    = run_q;
  assign out_range = flags[1] | (ctl_q.dual & flags[0]);
  assign overflow  = ovf_q;
endmodule

// File: rtl/adc_lane_framer_chk.sv
module adc_lane_framer_chk (
  input logic clk,
  input logic rst,
  input logic pwr_down,
  input logic smp_valid,
  input logic smp_ready,
  input logic overflow,
  input logic clk_en,
  input logic frame,
  input logic lane1_bit,
  input logic lane0_en
);
  // R10
  pd_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (!clk_en && !frame));

  // R10
  pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> $stable(lane1_bit));

  // R11
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !smp_ready) |=> overflow);

  // R9
  mode_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lane0_en) |-> $rose(frame));

  // R3
  frame_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(frame) && !pwr_down) |=> frame);
endmodule

bind adc_lane_framer adc_lane_framer_chk u_chk (
  .clk(clk), .rst(rst), .pwr_down(pwr_down), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .overflow(overflow), .clk_en(clk_en),
  .frame(frame), .lane1_bit(lane1_bit), .lane0_en(lane0_en)
);

// File: tb/sim_adc_lane_framer.sv
module sim_adc_lane_framer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0, smp_ovr = 1'b0;
  logic [11:0] smp_code = '0;
  logic dual_lane = 1'b0, word_align = 1'b0, twos_fmt = 1'b0, test_en = 1'b0;
  logic pwr_down = 1'b1;
  logic smp_ready, lane1_bit, lane0_bit, lane0_en, frame, clk_en, out_range, overflow;

  int checks = 0;
  int errs = 0;
  logic l1 [48], l0 [48], fr [48], en [48], ce [48], orr [48];

  always #5 clk = ~clk;

  adc_lane_framer u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_code(smp_code), .smp_ovr(smp_ovr), .dual_lane(dual_lane),
    .word_align(word_align), .twos_fmt(twos_fmt), .test_en(test_en),
    .pwr_down(pwr_down), .lane1_bit(lane1_bit), .lane0_bit(lane0_bit),
    .lane0_en(lane0_en), .frame(frame), .clk_en(clk_en),
    .out_range(out_range), .overflow(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic restart(input logic d, input logic a, input logic t2, input logic tp);
    @(negedge clk);
    rst = 1'b1; pwr_down = 1'b1; smp_valid = 1'b0;
    dual_lane = d; word_align = a; twos_fmt = t2; test_en = tp;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [11:0] c, input logic o);
    @(negedge clk);
    smp_valid = 1'b1; smp_code = c; smp_ovr = o;
    @(negedge clk);
    smp_valid = 1'b0; smp_ovr = 1'b0;
  endtask

  task automatic record(input int t);
    l1[t] = lane1_bit; l0[t] = lane0_bit; fr[t] = frame;
    en[t] = lane0_en; ce[t] = clk_en; orr[t] = out_range;
  endtask

  // Release power-down and record n ticks starting at tick 0.
  task automatic run_ticks(input int n);
    pwr_down = 1'b0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      record(t);
    end
  endtask

  function automatic int word_at(input bit lane1, input int t);
    logic [11:0] w;
    for (int b = 0; b < 12; b++) w[11-b] = lane1 ? l1[t+b] : l0[t+b];
    return int'(w);
  endfunction

  task automatic t_reset();
    restart(0, 0, 0, 0);
    @(negedge clk);
    chk("R1 clk_en", int'(clk_en), 0);
    chk("R1 frame", int'(frame), 0);
    chk("R1 lane0_en", int'(lane0_en), 0);
    chk("R1 lane1_bit", int'(lane1_bit), 0);
    chk("R1 out_range", int'(out_range), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 smp_ready", int'(smp_ready), 1);
  endtask

  task automatic t_single();
    int bad_fr, bad_en, bad_ce;
    restart(0, 0, 0, 0);
    push(12'h5C3, 0); push(12'h0A7, 0);
    run_ticks(24);
    chk("R2 first word", word_at(1, 0), 'h5C3);
    chk("R2 second word", word_at(1, 12), 'h0A7);
    bad_fr = 0; bad_en = 0; bad_ce = 0;
    for (int t = 0; t < 24; t++) begin
      if (fr[t] != ((t % 12) < 6)) bad_fr++;
      if (en[t] != 1'b0) bad_en++;
      if (ce[t] != 1'b1) bad_ce++;
    end
    chk("R3 frame shape mismatches", bad_fr, 0);
    chk("R3 clk_en low ticks", bad_ce, 0);
    chk("R2 lane0_en high ticks", bad_en, 0);
    chk("R7 out_range normal sample", int'(orr[0]), 0);
  endtask

  task automatic t_format();
    restart(0, 0, 1, 0);
    push(12'h123, 0); push(12'h9F0, 0);
    run_ticks(24);
    chk("R6 twos word a", word_at(1, 0), 'h923);
    chk("R6 twos word b", word_at(1, 12), 'h1F0);
  endtask

  task automatic t_overrange();
    restart(0, 0, 0, 0);
    push(12'hF00, 1); push(12'h100, 1);
    run_ticks(36);
    chk("R7 high clamp", word_at(1, 0), 'hFFF);
    chk("R7 flag high word", int'(orr[0]), 1);
    chk("R7 low clamp", word_at(1, 12), 'h000);
    chk("R7 flag low word", int'(orr[12]), 1);
    chk("R12 idle word", word_at(1, 24), 0);
    chk("R12 idle flag", int'(orr[24]), 0);
  endtask

  task automatic t_test();
    restart(1, 1, 0, 1);
    push(12'h111, 0); push(12'h222, 0);
    run_ticks(12);
    chk("R8 lane1 pattern", word_at(1, 0), 'hA63);
    chk("R8 lane0 pattern", word_at(0, 0), 'hA63);
  endtask

  task automatic t_dual_aligned();
    restart(1, 1, 0, 0);
    push(12'h3C5, 0); push(12'hC3A, 0);
    run_ticks(12);
    chk("R4 lane1 older", word_at(1, 0), 'h3C5);
    chk("R5 aligned lane0", word_at(0, 0), 'hC3A);
    chk("R4 lane0_en", int'(en[0]), 1);
  endtask

  task automatic t_dual_offset();
    restart(1, 0, 0, 0);
    push(12'h6B1, 0); push(12'h94E, 0);
    run_ticks(18);
    chk("R4 lane1 word", word_at(1, 0), 'h6B1);
    chk("R5 offset lane0", word_at(0, 6), 'h94E);
    chk("R5 frame high tick5", int'(fr[5]), 1);
    chk("R5 frame low tick6", int'(fr[6]), 0);
  endtask

  task automatic t_boundary();
    restart(0, 0, 0, 0);
    push(12'h5A5, 0); push(12'h0F0, 0);
    pwr_down = 1'b0;
    for (int t = 0; t < 24; t++) begin
      @(negedge clk);
      record(t);
      if (t == 3) begin
        dual_lane = 1'b1; word_align = 1'b1; test_en = 1'b1;
      end
    end
    chk("R9 word unchanged", word_at(1, 0), 'h5A5);
    chk("R9 lane0_en before boundary", int'(en[11]), 0);
    chk("R9 lane0_en at boundary", int'(en[12]), 1);
    chk("R9 lane1 pattern next word", word_at(1, 12), 'hA63);
    chk("R9 lane0 pattern next word", word_at(0, 12), 'hA63);
  endtask

  task automatic t_power();
    logic held;
    int moved;
    restart(0, 0, 0, 0);
    push(12'h7E1, 0); push(12'h81F, 0);
    run_ticks(5);
    held = l1[4];
    chk("R2 tick4 bit", int'(held), 1);
    pwr_down = 1'b1;
    moved = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (clk_en !== 1'b0 || frame !== 1'b0) moved++;
      if (lane1_bit !== held) moved++;
    end
    chk("R10 frozen mismatches", moved, 0);
    run_ticks(12);
    chk("R10 resume word", word_at(1, 0), 'h81F);
    chk("R10 resume frame", int'(fr[0]), 1);
  endtask

  task automatic t_overflow();
    restart(0, 0, 0, 0);
    push(12'h111, 0);
    chk("R11 ready one entry", int'(smp_ready), 1);
    push(12'h222, 0);
    chk("R11 ready full", int'(smp_ready), 0);
    smp_valid = 1'b1; smp_code = 12'h333;
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R11 overflow pulse", int'(overflow), 1);
    @(negedge clk);
    chk("R11 overflow clears", int'(overflow), 0);
    run_ticks(36);
    chk("R11 word a", word_at(1, 0), 'h111);
    chk("R11 word b", word_at(1, 12), 'h222);
    chk("R11 dropped sample absent", word_at(1, 24), 0);
  endtask

  initial begin
    #2_000_000;
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_format();
    t_overrange();
    t_test();
    t_dual_aligned();
    t_dual_offset();
    t_boundary();
    t_power();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule